// File: doc/BRIEF.md
# Pipelined Adaptive Decision-Feedback Equalizer

This block equalizes a binary symbol stream received over a channel with intersymbol interference. Each clock it takes one received sample and runs it through a feedforward tapped filter. In the same cycle it runs the symbols already decided through a feedback tapped filter. The sum of both filters goes into a delay line of D1 stages, and a sign slicer reads the far end of that line. The slicer turns the sum into a hard decision of plus or minus a fixed reference amplitude. The difference between the chosen symbol level and the slicer input is the error that drives adaptation.

The D1 stages of delay at the slicer and the D2-deep rotation of coefficient sets pipeline the block. They break the decision loop and the coefficient update loop, so the multiply-add trees can be retimed. The price is that the feedback filter cannot remove the first D1 postcursor terms. Both coefficient sets are adapted in one update that adds up the last LA products of error and regressor. The regressor is the exact vector that produced the sum now at the slicer. A training flag substitutes known symbols for the decisions, in the error and in the feedback history alike. A host normally raises it for the first few hundred samples and then drops it for decision-directed tracking.

Top module: `dfe_pipe`

## Requirements
- R1: While reset is high, and at the first sample after reset falls, dec_out is 0 and err_out is 0. Every coefficient is zero except feedforward tap MAIN, which holds unity (1 << FRAC). The sample and symbol histories are cleared, and a cleared symbol counts as the negative symbol.
- R2: The slicer input z(n) equals y(n-D1), the filter sum of D1 cycles earlier. The delay line is cleared on reset, so for the first D1 samples after reset err_out is exactly +AMP or -AMP.
- R3: The decision is 1 (symbol +AMP) when z(n) >= 0 and 0 (symbol -AMP) when z(n) < 0. dec_out shows the decision for the sample of the previous clock.
- R4: The error is the chosen symbol level minus z(n): +AMP - z for symbol 1, -AMP - z for symbol 0. err_out is registered in the same cycle as dec_out.
- R5: While train_en is high, train_sym (1 = +AMP, 0 = -AMP) replaces the slicer decision, both in the error and in the symbol pushed into the feedback history. dec_out still shows the slicer's own decision.
- R6: The regressor v(n) holds, in order, x_in of the current cycle, the NF-1 previous samples, and then the symbols a(n-1) down to a(n-NB), each as +AMP or -AMP.
- R7: The coefficient vector follows W(n) = W(n-D2) + ((sum over i < LA of e(n-i) * v(n-D1-i)) >>> MU_SH). The shift is arithmetic (a floor), and the result wraps to CW bits. The filter always uses W(n-D2).
- R8: The filter sum is y(n) = floor(sum over k of W(n-D2)[k] * v(n)[k] / 2^FRAC).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | W | Received sample, signed |
| train_en | input | 1 | Use train_sym instead of the decision |
| train_sym | input | 1 | Known symbol: 1 = +AMP, 0 = -AMP |
| dec_out | output | 1 | Registered slicer decision: 1 = +AMP |
| err_out | output | W+CW+clog2(NF+NB)+2-FRAC | Registered signed error, level minus slicer input |

## Verification
A wrong coefficient, regressor entry or delay-line entry leaves the error and the decision alone for exactly D1 cycles. After that it shows up as an error value that is off by the mis-weighted product. A slip in the update alignment, D2 rotation or LA history changes the coefficients. The change reaches err_out D1 + 1 clocks after the update that went wrong, and it grows from there. The bench sweeps reset, training, decision-directed runs, an isolated impulse and random training toggles, and compares both outputs every cycle. Most faults therefore show up within a few samples of the first cycle they affect.

// File: rtl/dfe_pkg.sv
`timescale 1ns/1ps
package dfe_pkg;
  // Hard symbol: the slicer and training inputs share this encoding.
  typedef enum logic {
    SYM_NEG = 1'b0,
    SYM_POS = 1'b1
  } sym_e;
endpackage

// File: rtl/dfe_regvec.sv
`timescale 1ns/1ps
// Regressor builder: current sample, past samples, past symbols as +/-AMP.
module dfe_regvec #(
  parameter int NF  = 13,
  parameter int NB  = 10,
  parameter int W   = 8,
  parameter int AMP = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] x_in,
  input  logic                sym_in,
  output logic signed [W-1:0] vec [NF+NB]
);
  localparam logic signed [W-1:0] LV = W'(AMP);

  logic signed [W-1:0] xs [NF-1];
  logic                sh [NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NF-1; i++) xs[i] <= '0;
      for (int j = 0; j < NB; j++)   sh[j] <= 1'b0;
    end else begin
      xs[0] <= x_in;
      for (int i = 1; i < NF-1; i++) xs[i] <= xs[i-1];
      sh[0] <= sym_in;
      for (int j = 1; j < NB; j++)   sh[j] <= sh[j-1];
    end
  end

  always_comb begin
    vec[0] = x_in;
    for (int i = 1; i < NF; i++) vec[i] = xs[i-1];
    for (int j = 0; j < NB; j++) vec[NF+j] = sh[j] ? LV : -LV;
  end
endmodule

// File: rtl/dfe_dot.sv
`timescale 1ns/1ps
// Combined dot product of coefficients and regressor, scaled down by FRAC.
module dfe_dot #(
  parameter int NT   = 23,
  parameter int W    = 8,
  parameter int CW   = 16,
  parameter int ACCW = 30,
  parameter int FRAC = 12
) (
  input  logic signed [CW-1:0]        w [NT],
  input  logic signed [W-1:0]         v [NT],
  output logic signed [ACCW-FRAC-1:0] y
);
  logic signed [ACCW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < NT; k++)
      acc = acc + ACCW'(w[k]) * ACCW'(v[k]);
  end

  assign y = (ACCW-FRAC)'(acc >>> FRAC);
endmodule

// File: rtl/dfe_lms.sv
`timescale 1ns/1ps
// Coefficient adaptation: D2 interleaved coefficient sets, LA-term relaxed sum.
module dfe_lms #(
  parameter int NT    = 23,
  parameter int W     = 8,
  parameter int CW    = 16,
  parameter int EW    = 19,
  parameter int D1    = 5,
  parameter int D2    = 1,
  parameter int LA    = 1,
  parameter int MU_SH = 12,
  parameter int FRAC  = 12,
  parameter int MAIN  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [EW-1:0] err,
  input  logic signed [W-1:0]  vec   [NT],
  output logic signed [CW-1:0] w_use [NT]
);
  localparam int VD = D1 + LA - 1;
  localparam int SW = EW + W + $clog2(LA) + 1;
  localparam logic signed [CW-1:0] ONE = CW'(1 << FRAC);

  logic signed [W-1:0]  vdl  [VD][NT];
  logic signed [CW-1:0] wdl  [D2][NT];
  logic signed [CW-1:0] wnew [NT];
  logic signed [SW-1:0] gsum [NT];
  logic signed [EW-1:0] esel [LA];

  assign esel[0] = err;

  generate
    if (LA > 1) begin : g_ehist
      logic signed [EW-1:0] eh [LA-1];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < LA-1; i++) eh[i] <= '0;
        end else begin
          eh[0] <= err;
          for (int i = 1; i < LA-1; i++) eh[i] <= eh[i-1];
        end
      end
      for (genvar g = 1; g < LA; g++) begin : g_tap
        assign esel[g] = eh[g-1];
      end
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < NT; k++) begin
      gsum[k] = '0;
      for (int i = 0; i < LA; i++)
        gsum[k] = gsum[k] + SW'(esel[i]) * SW'(vdl[D1+i-1][k]);
      wnew[k] = wdl[D2-1][k] + CW'(gsum[k] >>> MU_SH);
    end
  end

  assign w_use = wdl[D2-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < D2; j++)
        for (int k = 0; k < NT; k++)
          wdl[j][k] <= (k == MAIN) ? ONE : '0;
      for (int j = 0; j < VD; j++)
        for (int k = 0; k < NT; k++)
          vdl[j][k] <= '0;
    end else begin
      wdl[0] <= wnew;
      for (int j = 1; j < D2; j++) wdl[j] <= wdl[j-1];
      vdl[0] <= vec;
      for (int j = 1; j < VD; j++) vdl[j] <= vdl[j-1];
    end
  end
endmodule

// File: rtl/dfe_pipe.sv
`timescale 1ns/1ps
// Pipelined adaptive decision-feedback equalizer, binary symbols.
module dfe_pipe #(
  parameter int NF    = 13,
  parameter int NB    = 10,
  parameter int W     = 8,
  parameter int CW    = 16,
  parameter int FRAC  = 12,
  parameter int AMP   = 32,
  parameter int D1    = 5,
  parameter int D2    = 1,
  parameter int LA    = 1,
  parameter int MU_SH = 12,
  parameter int MAIN  = 6
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic signed [W-1:0]                          x_in,
  input  logic                                         train_en,
  input  logic                                         train_sym,
  output logic                                         dec_out,
  output logic signed [W+CW+$clog2(NF+NB)+2-FRAC-1:0]  err_out
);
  import dfe_pkg::*;

  localparam int NT   = NF + NB;
  localparam int ACCW = W + CW + $clog2(NT) + 1;
  localparam int ZW   = ACCW - FRAC;
  localparam int EW   = ZW + 1;

  logic signed [W-1:0]  vec  [NT];
  logic signed [CW-1:0] wcur [NT];
  logic signed [ZW-1:0] ysum;
  logic signed [ZW-1:0] z;
  logic signed [ZW-1:0] ydl  [D1];
  logic signed [EW-1:0] lev;
  logic signed [EW-1:0] ecur;
  sym_e                 qsym;
  sym_e                 asym;

  dfe_regvec #(.NF(NF), .NB(NB), .W(W), .AMP(AMP)) u_vec (
    .clk(clk), .rst(rst), .x_in(x_in), .sym_in(asym), .vec(vec)
  );

  dfe_dot #(.NT(NT), .W(W), .CW(CW), .ACCW(ACCW), .FRAC(FRAC)) u_dot (
    .w(wcur), .v(vec), .y(ysum)
  );

  dfe_lms #(.NT(NT), .W(W), .CW(CW), .EW(EW), .D1(D1), .D2(D2), .LA(LA),
            .MU_SH(MU_SH), .FRAC(FRAC), .MAIN(MAIN)) u_lms (
    .clk(clk), .rst(rst), .err(ecur), .vec(vec), .w_use(wcur)
  );

  // Slicer sees the filter sum D1 samples late.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < D1; i++) ydl[i] <= '0;
    end else begin
      ydl[0] <= ysum;
      for (int i = 1; i < D1; i++) ydl[i] <= ydl[i-1];
    end
  end

  assign z = ydl[D1-1];

  always_comb begin
    qsym = z[ZW-1] ? SYM_NEG : SYM_POS;
    asym = train_en ? sym_e'(train_sym) : qsym;
    lev  = (asym == SYM_POS) ? EW'(AMP) : -EW'(AMP);
    ecur = lev - EW'(z);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_out <= 1'b0;
      err_out <= '0;
    end else begin
      dec_out <= (qsym == SYM_POS);
      err_out <= ecur;
    end
  end
endmodule

// File: rtl/dfe_pipe_chk.sv
`timescale 1ns/1ps
module dfe_pipe_chk #(
  parameter int AMP = 32,
  parameter int D1  = 5,
  parameter int EW  = 19
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 train_en,
  input logic                 train_sym,
  input logic                 dec_out,
  input logic signed [EW-1:0] err_out
);
  localparam int CNTW = $clog2(D1 + 2) + 1;
  localparam logic signed [EW-1:0] LV = EW'(AMP);

  logic [CNTW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since <= CNTW'(D1)) since <= since + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!dec_out && err_out == '0));

  // R2
  early_err_level_chk: assert property (@(posedge clk) disable iff (rst)
    (since >= CNTW'(1) && since <= CNTW'(D1)) |-> (err_out == LV || err_out == -LV));

  // R3
  dd_pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(train_en) && dec_out) |-> (err_out <= LV));

  // R3
  dd_neg_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(train_en) && !dec_out) |-> (err_out > -LV));

  // R5
  train_neg_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(train_en) && !$past(train_sym) && dec_out) |-> (err_out <= -LV));

  // R5
  train_pos_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(train_en) && $past(train_sym) && !dec_out) |-> (err_out > LV));
endmodule

bind dfe_pipe dfe_pipe_chk #(.AMP(AMP), .D1(D1), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .train_en(train_en), .train_sym(train_sym),
  .dec_out(dec_out), .err_out(err_out)
);

// File: tb/sim_dfe_pipe.sv
`timescale 1ns/1ps
module sim_dfe_pipe;
  localparam int NF = 3, NB = 2, W = 8, CW = 16, FRAC = 8, AMP = 32;
  localparam int D1 = 2, D2 = 2, LA = 2, MU_SH = 10, MAIN = 1;
  localparam int NT = NF + NB;
  localparam int VD = D1 + LA - 1;
  localparam int EW = W + CW + $clog2(NT) + 2 - FRAC;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic signed [W-1:0]  x_in = '0;
  logic                 train_en = 1'b0;
  logic                 train_sym = 1'b0;
  logic                 dec_out;
  logic signed [EW-1:0] err_out;

  always #10 clk = ~clk;

  dfe_pipe #(.NF(NF), .NB(NB), .W(W), .CW(CW), .FRAC(FRAC), .AMP(AMP), .D1(D1),
             .D2(D2), .LA(LA), .MU_SH(MU_SH), .MAIN(MAIN)) u0 (
    .clk(clk), .rst(rst), .x_in(x_in), .train_en(train_en),
    .train_sym(train_sym), .dec_out(dec_out), .err_out(err_out)
  );

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  bit  armed = 1'b0;
  int  post_rst = 0;

  // Arithmetic reference state
  longint m_xs  [NF-1];
  bit     m_ah  [NB];
  longint m_ydl [D1];
  longint m_vdl [VD][NT];
  longint m_eh  [LA];
  longint m_w   [D2][NT];
  bit     m_dec;
  longint m_err;

  logic [15:0] lf = 16'hACE1;
  bit          txh [8];

  function automatic longint wrapc(input longint v);
    logic signed [CW-1:0] t;
    t = v[CW-1:0];
    return longint'(t);
  endfunction

  function bit lbit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NF-1; i++) m_xs[i] = 0;
    for (int j = 0; j < NB; j++) m_ah[j] = 1'b0;
    for (int i = 0; i < D1; i++) m_ydl[i] = 0;
    for (int j = 0; j < VD; j++) for (int k = 0; k < NT; k++) m_vdl[j][k] = 0;
    for (int i = 0; i < LA; i++) m_eh[i] = 0;
    for (int j = 0; j < D2; j++)
      for (int k = 0; k < NT; k++) m_w[j][k] = (k == MAIN) ? (64'sd1 <<< FRAC) : 0;
    m_dec = 1'b0;
    m_err = 0;
    post_rst = 0;
  endtask

  task automatic m_step(input longint x, input bit tr, input bit ts);
    longint v [NT];
    longint nw [NT];
    longint acc, y, z, e, s, ei;
    bit q, a;
    v[0] = x;
    for (int k = 1; k < NF; k++) v[k] = m_xs[k-1];
    for (int j = 0; j < NB; j++) v[NF+j] = m_ah[j] ? AMP : -AMP;
    acc = 0;
    for (int k = 0; k < NT; k++) acc += m_w[D2-1][k] * v[k];
    y = acc >>> FRAC;
    z = m_ydl[D1-1];
    q = (z >= 0);
    a = tr ? ts : q;
    e = (a ? AMP : -AMP) - z;
    for (int k = 0; k < NT; k++) begin
      s = 0;
      for (int i = 0; i < LA; i++) begin
        if (i == 0) ei = e; else ei = m_eh[i-1];
        s += ei * m_vdl[D1+i-1][k];
      end
      nw[k] = wrapc(m_w[D2-1][k] + (s >>> MU_SH));
    end
    for (int j = D2-1; j > 0; j--) for (int k = 0; k < NT; k++) m_w[j][k] = m_w[j-1][k];
    for (int k = 0; k < NT; k++) m_w[0][k] = nw[k];
    for (int j = VD-1; j > 0; j--) for (int k = 0; k < NT; k++) m_vdl[j][k] = m_vdl[j-1][k];
    for (int k = 0; k < NT; k++) m_vdl[0][k] = v[k];
    for (int i = LA-1; i > 0; i--) m_eh[i] = m_eh[i-1];
    m_eh[0] = e;
    for (int i = D1-1; i > 0; i--) m_ydl[i] = m_ydl[i-1];
    m_ydl[0] = y;
    for (int i = NF-2; i > 0; i--) m_xs[i] = m_xs[i-1];
    m_xs[0] = x;
    for (int j = NB-1; j > 0; j--) m_ah[j] = m_ah[j-1];
    m_ah[0] = a;
    m_dec = q;
    m_err = e;
    post_rst++;
  endtask

  task automatic compare(input string dtag, input string etag);
    if (!armed) return;
    checks++;
    if (dec_out !== m_dec) begin
      errors++;
      $display("FAIL %s dec_out actual %0d expected %0d", dtag, dec_out, m_dec);
    end
    checks++;
    if (err_out !== EW'(m_err)) begin
      errors++;
      $display("FAIL %s err_out actual %0d expected %0d", etag, err_out, m_err);
    end
    if (post_rst == 0) begin
      // R1: cleared outputs right after reset
      checks++;
      if (dec_out !== 1'b0 || err_out !== '0) begin
        errors++;
        $display("FAIL R1 reset outputs actual %0d/%0d expected 0/0", dec_out, err_out);
      end
    end else if (post_rst <= D1) begin
      // R2: slicer input still zero, error is a bare symbol level
      checks++;
      if (err_out !== EW'(AMP) && err_out !== -EW'(AMP)) begin
        errors++;
        $display("FAIL R2 early err_out actual %0d expected +/-%0d", err_out, AMP);
      end
    end
  endtask

  task automatic cyc(input longint x, input bit tr, input bit ts, input bit do_rst,
                     input string dtag, input string etag);
    @(negedge clk);
    compare(dtag, etag);
    rst = do_rst;
    x_in = W'(x);
    train_en = tr;
    train_sym = ts;
    if (do_rst) m_reset();
    else m_step(x, tr, ts);
    armed = 1'b1;
  endtask

  function longint chan_sample();
    for (int i = 7; i > 0; i--) txh[i] = txh[i-1];
    txh[0] = lbit();
    return (txh[0] ? 4 : -4) + (txh[1] ? 24 : -24) + (txh[2] ? 10 : -10) + (txh[3] ? -6 : 6);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run hung: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    longint xv;
    for (int i = 0; i < 8; i++) txh[i] = 1'b0;
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(0, 1'b0, 1'b0, 1'b1, "R1", "R1");
    // R2: filling delay line, R5 training over channel samples, R4 error
    for (int i = 0; i < 250; i++) begin
      xv = chan_sample();
      cyc(xv, 1'b1, txh[1 + D1], 1'b0, "R2 R5 training decision", "R4 R5 training error");
    end
    // R3 R6 R7 R8: decision-directed tracking
    for (int i = 0; i < 250; i++) begin
      xv = chan_sample();
      cyc(xv, 1'b0, 1'b0, 1'b0, "R3 R6 decision", "R7 R8 error");
    end
    // R1 again: reset in mid-run
    for (int i = 0; i < 2; i++) cyc(0, 1'b0, 1'b0, 1'b1, "R1", "R1");
    // R8 R6: isolated impulse through main tap, then silence
    cyc(64, 1'b1, 1'b1, 1'b0, "R8 impulse decision", "R8 impulse error");
    for (int i = 0; i < 20; i++) cyc(0, 1'b1, 1'b1, 1'b0, "R6 R8 tail decision", "R7 tail error");
    cyc(-100, 1'b0, 1'b0, 1'b0, "R3 negative impulse", "R4 negative impulse");
    for (int i = 0; i < 20; i++) cyc(0, 1'b0, 1'b0, 1'b0, "R3 tail decision", "R4 tail error");
    // R5 R7: random samples with training toggled per cycle
    for (int i = 0; i < 150; i++) begin
      xv = (lbit() ? 1 : -1) * longint'({lbit(), lbit(), lbit(), lbit(), lbit()});
      cyc(xv, lbit(), lbit(), 1'b0, "R5 toggle decision", "R5 R7 toggle error");
    end
    cyc(0, 1'b0, 1'b0, 1'b0, "R3 final", "R4 final");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule